// File: doc/BRIEF.md
# Path-History Indirect Branch Target Predictor

This block predicts where an indirect branch will go. It keeps a 15-bit record of the recent control-flow path. Taken conditional branches and resolved indirect branches fold address bits into this record. Every other kind of branch leaves it alone. When an indirect branch is looked up, its address is mixed with the path record into a 15-bit hash. Eight bits of the hash select one entry of a 256-entry direct-mapped target table, and seven bits form the entry tag.

Resolved branches arrive one per cycle on a retire stream that carries the kind, the outcome, the address and the target. A resolved indirect branch writes its target into the table. The table location and tag for that write come from the path record as it stood before that same branch folded itself in. The lookup port is purely combinational over the current state. It only claims a hit when the companion target buffer also reports a hit for the same fetch address.

Top module: `ind_path_pred`

## Requirements
- R1: While reset is asserted and after reset is released, the path record is zero and every table entry is invalid, so no lookup reports a hit until an indirect branch has been written.
- R2: A retired taken conditional branch (kind 0, taken 1) sets the path record to (record shifted left by two, kept to 15 bits) XOR address bits [18:4].
- R3: A retired indirect branch (kind 4) sets the path record to (record shifted left by two, kept to 15 bits) XOR the 13-bit value {address[18:12], target[5:0]}, placed in record bits [12:0].
- R4: A not-taken conditional (kind 0, taken 0), a direct jump (kind 1), a call (kind 2), a return (kind 3), any kind from 5 to 7, and a cycle without a retired branch all leave the path record unchanged.
- R5: The hash h is formed as h[5:0] = address[17:12] XOR record[5:0], h[13:6] = address[11:4] XOR record[13:6], and h[14] = address[12] XOR record[14]. Address bit 18 does not take part in the hash.
- R6: The table is direct-mapped with 256 entries. The index is h[13:6] and the tag is {h[14], h[5:0]}. A lookup hits only when the indexed entry is valid and its tag matches, and a later write with a different tag at the same index displaces the earlier entry.
- R7: The hit output is low whenever the target-buffer hit input is low, whatever the table holds.
- R8: A retired indirect branch writes its full target and its tag into the entry chosen by the hash of its address with the path record before its own update, and marks that entry valid.
- R9: Lookup outputs reflect the state before the current cycle's retirement. A write or path change made by a branch retired in one cycle becomes visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | A branch retires this cycle |
| upd_kind | input | 3 | Branch kind: 0 conditional, 1 jump, 2 call, 3 return, 4 indirect |
| upd_taken | input | 1 | Resolved outcome of a conditional branch |
| upd_pc | input | ADDR_W | Address of the retiring branch |
| upd_target | input | TGT_W | Resolved target of the retiring branch |
| lk_pc | input | ADDR_W | Address of the indirect branch being looked up |
| lk_btb_hit | input | 1 | Companion target buffer hits for lk_pc |
| lk_hit | output | 1 | Prediction available |
| lk_target | output | TGT_W | Predicted target, meaningful when lk_hit is high |

## Verification
A lookup and the retirement of an indirect branch can fall in the same cycle. This can even happen at the very table entry and path state being looked up. The bench provokes this by presenting the lookup address on the lookup port while the same branch retires. It expects a miss in that cycle, because the lookup must see the older state. It then brings the path record back to zero with a cancelling taken conditional and expects the written target one cycle later. The bench also applies path updates and lookups together throughout the vector walk. A reference model that follows the requirements predicts every lookup.

// File: rtl/ind_path_pred.sv
module ind_path_pred #(
  parameter int ADDR_W = 32,
  parameter int TGT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [2:0]        upd_kind,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [TGT_W-1:0]  upd_target,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_btb_hit,
  output logic              lk_hit,
  output logic [TGT_W-1:0]  lk_target
);

  localparam int HIST_W = 15;
  localparam int IDX_W  = 8;
  localparam int TAG_W  = 7;
  localparam int DEPTH  = 1 << IDX_W;
  localparam logic [2:0] K_COND = 3'd0;
  localparam logic [2:0] K_IND  = 3'd4;

  logic [HIST_W-1:0] path_q;
  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [TGT_W-1:0]  tgt_q [DEPTH];

  function automatic logic [HIST_W-1:0] mix(input logic [ADDR_W-1:0] pc,
                                            input logic [HIST_W-1:0] p);
    logic [HIST_W-1:0] h;
    h[5:0]  = pc[17:12] ^ p[5:0];
    h[13:6] = pc[11:4]  ^ p[13:6];
    h[14]   = pc[12]    ^ p[14];
    return h;
  endfunction

  logic [HIST_W-1:0] lk_h, wr_h;
  logic [IDX_W-1:0]  lk_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, wr_tag;

  assign lk_h   = mix(lk_pc, path_q);
  assign wr_h   = mix(upd_pc, path_q);
  assign lk_idx = lk_h[13:6];
  assign wr_idx = wr_h[13:6];
  assign lk_tag = {lk_h[14], lk_h[5:0]};
  assign wr_tag = {wr_h[14], wr_h[5:0]};

  logic is_ind, is_tcond;
  logic [HIST_W-1:0] contrib;

  assign is_ind   = upd_valid && (upd_kind == K_IND);
  assign is_tcond = upd_valid && (upd_kind == K_COND) && upd_taken;
  assign contrib  = is_tcond ? upd_pc[18:4]
                             : {2'b00, upd_pc[18:12], upd_target[5:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      path_q <= '0;
      vld_q  <= '0;
    end else begin
      if (is_tcond || is_ind)
        path_q <= {path_q[HIST_W-3:0], 2'b00} ^ contrib;
      if (is_ind)
        vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && is_ind) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= upd_target;
    end
  end

  assign lk_hit    = lk_btb_hit && vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_target = tgt_q[lk_idx];

  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (path_q == '0) && (vld_q == '0));

  p_path_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid || (upd_kind != K_IND && !(upd_kind == K_COND && upd_taken)))
      |=> $stable(path_q));

  p_write_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    is_ind |=> vld_q[$past(wr_idx)]);

  p_hit_needs_btb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_btb_hit);

  p_valid_only_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !is_ind |=> $stable(vld_q));

endmodule

// File: tb/test_ind_path_pred.sv
module test_ind_path_pred;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [2:0]  upd_kind = 3'd1;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic [31:0] lk_pc = '0;
  logic        lk_btb_hit = 1'b1;
  logic        lk_hit;
  logic [31:0] lk_target;

  int checks = 0;
  int fails = 0;

  ind_path_pred i_ind_path_pred (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_kind(upd_kind),
    .upd_taken(upd_taken), .upd_pc(upd_pc), .upd_target(upd_target),
    .lk_pc(lk_pc), .lk_btb_hit(lk_btb_hit), .lk_hit(lk_hit),
    .lk_target(lk_target));

  always #(CLK_P/2) clk = ~clk;

  logic [14:0] mp;
  logic        mv [256];
  logic [6:0]  mt [256];
  logic [31:0] mg [256];

  function automatic logic [14:0] mhash(input logic [31:0] pc, input logic [14:0] p);
    return {pc[12] ^ p[14], pc[11:4] ^ p[13:6], pc[17:12] ^ p[5:0]};
  endfunction

  task automatic model_reset();
    mp = '0;
    for (int i = 0; i < 256; i++) mv[i] = 1'b0;
  endtask

  task automatic model_update(input logic [2:0] k, input logic tk,
                              input logic [31:0] pc, input logic [31:0] tg);
    logic [14:0] h;
    if (k == 3'd4) begin
      h = mhash(pc, mp);
      mv[h[13:6]] = 1'b1;
      mt[h[13:6]] = {h[14], h[5:0]};
      mg[h[13:6]] = tg;
      mp = {mp[12:0], 2'b00} ^ {2'b00, pc[18:12], tg[5:0]};
    end else if (k == 3'd0 && tk) begin
      mp = {mp[12:0], 2'b00} ^ pc[18:4];
    end
  endtask

  task automatic check(input logic eh, input logic [31:0] et, input string req);
    checks++;
    if (lk_hit !== eh || (eh && lk_target !== et)) begin
      fails++;
      $display("FAIL %s: hit=%0b target=%08h expected hit=%0b target=%08h",
               req, lk_hit, lk_target, eh, et);
    end
  endtask

  task automatic check_model(input string req);
    logic [14:0] h;
    logic eh;
    h = mhash(lk_pc, mp);
    eh = lk_btb_hit && mv[h[13:6]] && (mt[h[13:6]] == {h[14], h[5:0]});
    check(eh, mg[h[13:6]], req);
  endtask

  task automatic step(input logic [2:0] k, input logic tk, input logic [31:0] pc,
                      input logic [31:0] tg, input logic [31:0] lpc,
                      input logic btb, input logic eh, input logic [31:0] et,
                      input logic use_lit, input string req);
    @(negedge clk);
    upd_valid = 1'b1; upd_kind = k; upd_taken = tk; upd_pc = pc; upd_target = tg;
    lk_pc = lpc; lk_btb_hit = btb;
    #1;
    if (use_lit) check(eh, et, req);
    else check_model(req);
    @(posedge clk);
    model_update(k, tk, pc, tg);
  endtask

  task automatic look(input logic [31:0] lpc, input logic btb,
                      input logic eh, input logic [31:0] et, input string req);
    @(negedge clk);
    upd_valid = 1'b0; lk_pc = lpc; lk_btb_hit = btb;
    #1;
    check(eh, et, req);
  endtask

  task automatic cancel();
    logic [14:0] s;
    s = {mp[12:0], 2'b00};
    step(3'd0, 1'b1, {13'b0, s, 4'b0}, 32'h0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b1, "R2");
  endtask

  typedef struct packed {
    logic [2:0]  kind;
    logic        tk;
    logic        zap;
    logic [31:0] pc;
    logic [31:0] tg;
    logic [31:0] lk;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{3'd4, 1'b0, 1'b0, 32'h0004_5670, 32'h1000_0040, 32'h0004_5670},
    '{3'd0, 1'b1, 1'b1, 32'h0,         32'h0,         32'h0004_5670},
    '{3'd1, 1'b0, 1'b0, 32'h0000_1230, 32'h0,         32'h0004_5670},
    '{3'd0, 1'b1, 1'b0, 32'h0001_2340, 32'h0,         32'h0004_5670},
    '{3'd4, 1'b0, 1'b0, 32'h0003_3330, 32'h2000_0abc, 32'h0003_3330},
    '{3'd0, 1'b0, 1'b0, 32'h0000_0010, 32'h0,         32'h0003_3330},
    '{3'd4, 1'b0, 1'b0, 32'h0007_7770, 32'h3000_0011, 32'h0004_5670},
    '{3'd0, 1'b1, 1'b1, 32'h0,         32'h0,         32'h0007_7770},
    '{3'd2, 1'b0, 1'b0, 32'h0000_4000, 32'h0,         32'h0007_7770},
    '{3'd3, 1'b0, 1'b0, 32'h0000_5000, 32'h0,         32'h0007_7770},
    '{3'd0, 1'b1, 1'b0, 32'h0000_0040, 32'h0,         32'h0007_7770},
    '{3'd7, 1'b1, 1'b0, 32'h0000_0080, 32'h0,         32'h0004_5670}
  };

  localparam logic [31:0] PA = 32'h0002_3450;
  localparam logic [31:0] TA = 32'h8000_1234;
  localparam logic [31:0] PB = 32'h0005_0000;
  localparam logic [31:0] TB = 32'h0000_0ac0;
  localparam logic [31:0] PC = 32'h0001_1110;
  localparam logic [31:0] TC = 32'h4444_0008;
  localparam logic [31:0] PD = 32'h0002_2450;
  localparam logic [31:0] TD = 32'h5555_0002;

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: run actual=hung expected=complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    look(PA, 1'b1, 1'b0, 32'h0, "R1 no hit in reset");
    @(negedge clk); rst_n = 1'b1;
    look(PA, 1'b1, 1'b0, 32'h0, "R1 empty after reset");

    for (int i = 0; i < 12; i++) begin
      if (VEC[i].zap) begin
        @(negedge clk); lk_pc = VEC[i].lk; lk_btb_hit = 1'b1; upd_valid = 1'b0;
        #1; check_model("R9 vector lookup");
        cancel();
      end else
        step(VEC[i].kind, VEC[i].tk, VEC[i].pc, VEC[i].tg, VEC[i].lk, 1'b1,
             1'b0, 32'h0, 1'b0, "R6 vector walk");
      @(negedge clk); upd_valid = 1'b0; lk_pc = VEC[i].lk; #1;
      check_model("R2 R3 R4 vector follow-up");
    end

    @(negedge clk); upd_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; model_reset();
    look(32'h0004_5670, 1'b1, 1'b0, 32'h0, "R1 reset clears entries");

    step(3'd4, 1'b0, PA, TA, PA, 1'b1, 1'b0, 32'h0, 1'b1, "R8 write at zero path");
    cancel();
    look(PA, 1'b1, 1'b1, TA, "R8 hit after cancel");
    look(PA, 1'b0, 1'b0, 32'h0, "R7 no btb hit");
    step(3'd0, 1'b0, 32'h0000_7770, 32'h0, PA, 1'b1, 1'b1, TA, 1'b1, "R4 before nt");
    look(PA, 1'b1, 1'b1, TA, "R4 after not-taken conditional");
    step(3'd1, 1'b0, 32'h0001_0010, 32'h0, PA, 1'b1, 1'b1, TA, 1'b1, "R4 before jump");
    step(3'd2, 1'b0, 32'h0002_0020, 32'h0, PA, 1'b1, 1'b1, TA, 1'b1, "R4 before call");
    step(3'd3, 1'b1, 32'h0003_0030, 32'h0, PA, 1'b1, 1'b1, TA, 1'b1, "R4 before return");
    step(3'd6, 1'b1, 32'h0004_0040, 32'h0, PA, 1'b1, 1'b1, TA, 1'b1, "R4 before kind 6");
    look(PA, 1'b1, 1'b1, TA, "R4 after jump call return kind6");
    look(PA ^ 32'h0002_0000, 1'b1, 1'b0, 32'h0, "R6 tag bit mismatch");
    look(PA ^ 32'h0004_0000, 1'b1, 1'b1, TA, "R5 address bit 18 ignored");

    step(3'd0, 1'b1, 32'h0000_0010, 32'h0, PA, 1'b1, 1'b1, TA, 1'b1, "R2 before taken");
    look(PA, 1'b1, 1'b0, 32'h0, "R2 path changed by taken conditional");
    step(3'd0, 1'b1, 32'h0000_0040, 32'h0, PA, 1'b1, 1'b0, 32'h0, 1'b1, "R2 shift by two");
    look(PA, 1'b1, 1'b1, TA, "R2 shift-by-two cancel restores path");

    step(3'd4, 1'b0, PB, TB, PB, 1'b1, 1'b0, 32'h0, 1'b1, "R3 write B");
    step(3'd0, 1'b1, 32'h0005_0000, 32'h0, PB, 1'b1, 1'b0, 32'h0, 1'b1, "R3 cancel contribution");
    look(PB, 1'b1, 1'b1, TB, "R3 indirect contribution cancelled");

    step(3'd4, 1'b0, PC, TC, PC, 1'b1, 1'b0, 32'h0, 1'b1, "R9 same-cycle lookup sees old");
    cancel();
    look(PC, 1'b1, 1'b1, TC, "R9 visible next cycle");

    step(3'd4, 1'b0, PD, TD, PA, 1'b1, 1'b1, TA, 1'b1, "R6 before overwrite");
    cancel();
    look(PA, 1'b1, 1'b0, 32'h0, "R6 displaced by same index");
    look(PD, 1'b1, 1'b1, TD, "R6 new entry hits");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule